// File: doc/BRIEF.md
# Two-Channel Direct Memory Access Controller

This block moves data between memory locations without the CPU copying it. It has two independent channels. Each channel holds a source pointer, a destination pointer, a transfer count and a small control word. A request line chosen in the control word starts one transfer. For each transfer the controller raises a bus request toward the CPU side. Once the request is granted it runs one read bus cycle and one write bus cycle, then drops its request for at least one cycle so that the CPU can use the bus.

Software sets up a channel through a write-only register port. It loads the pointers and the count, then writes the control word with the enable bit set. Each transfer moves one byte or one 16-bit word. The count drops by one per transfer. When the count runs out, the channel sets a sticky interrupt flag. In single mode the channel then disables itself. In repeat mode it reloads the pointers and count that were captured when it was enabled, and it keeps running.

Top module: `dma2ch`

## Requirements
- R1: After reset, bus_req_o, bus_en_o and bus_we_o are low and irq_o is 2'b00.
- R2: Register map. Offsets 0..3 are channel 0 and 4..7 are channel 1. Within a channel, offset 0 is the source pointer, 1 the destination pointer, 2 the count and 3 the control word. Control bits are: [0] enable, [1] word, [2] repeat, [3] source increment, [4] destination increment, [7:5] request select. In byte mode a transfer reads the source byte and writes it to the destination zero-extended to 16 bits. Incrementing pointers advance by 1.
- R3: In word mode (control bit 1 = 1) a transfer moves all 16 bits of bus data, and incrementing pointers advance by 2.
- R4: A pointer whose increment bit is 0 keeps its value across transfers. The source and destination increment bits act independently.
- R5: Request select codes are 0 external interrupt (req_i[0]), 1 timer (req_i[1]), 2 software, 3 UART transmit (req_i[3]), 4 UART receive (req_i[4]) and 5 A/D done (req_i[5]). A pulse on any other line does not start a transfer.
- R6: Requests that arrive while a channel's enable bit is 0 are ignored.
- R7: In single mode (control bit 2 = 0), the enable bit clears when the count reaches zero, and later requests cause no transfer.
- R8: In repeat mode, when the count reaches zero, the channel reloads the source pointer, destination pointer and count captured when its enable bit went from 0 to 1, and it stays enabled.
- R9: Each transfer is one read cycle (bus_en_o=1, bus_we_o=0) followed immediately by one write cycle (bus_en_o=1, bus_we_o=1). The next cycle has bus_req_o and bus_en_o low.
- R10: When both channels are pending at the same grant, channel 0 is served first.
- R11: irq_o[n] goes high when channel n's count reaches zero. It stays high until a register write to offset 8 has bit n set.
- R12: A read cycle begins only in the cycle after bus_gnt_i was high while bus_req_o was high and the bus was idle. With no grant, the request stays pending.
- R13: With select code 2, a register write to offset 9 that has bit n set starts one transfer on channel n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register offset |
| reg_wdata_i | input | ADDR_W | Register write data |
| req_i | input | 6 | Peripheral request lines, indexed by select code |
| bus_gnt_i | input | 1 | Bus grant from the CPU side |
| bus_rdata_i | input | 16 | Read data, returned in the same cycle |
| bus_req_o | output | 1 | Bus request |
| bus_en_o | output | 1 | Bus cycle active |
| bus_we_o | output | 1 | Write cycle when 1, read cycle when 0 |
| bus_word_o | output | 1 | 16-bit access when 1, byte access when 0 |
| bus_addr_o | output | ADDR_W | Byte address |
| bus_wdata_o | output | 16 | Write data |
| irq_o | output | 2 | Sticky per-channel completion flags |

## Verification
The assertions assume three things about the environment. Read data is returned in the same cycle. The grant is only sampled while the controller is idle, and the controller does not wait for it again during a transfer. Software never writes a channel's registers in the same cycle that channel finishes a transfer. The stimulus keeps within these limits: the bench memory answers reads combinationally, and the grant is changed only while no transfer is running. All register writes happen after a channel has drained, and the source and destination regions never overlap, so the expected data can be read from the bench's own memory image.

// File: rtl/dma2ch_pkg.sv
package dma2ch_pkg;
  localparam int NCH  = 2;
  localparam int NSRC = 6;
  localparam logic [3:0] REG_STAT = 4'h8;
  localparam logic [3:0] REG_SWT  = 4'h9;
  localparam logic [2:0] SEL_SW   = 3'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_GAP} eng_st_e;

  typedef struct packed {
    logic [2:0] sel;
    logic       dst_inc;
    logic       src_inc;
    logic       rpt;
    logic       word;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma2ch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_src_i,
  input  logic              wr_dst_i,
  input  logic              wr_cnt_i,
  input  logic              wr_ctrl_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              sw_trig_i,
  input  logic [NSRC-1:0]   req_i,
  input  logic              irq_clr_i,
  input  logic              start_i,
  input  logic              done_i,
  output logic              pend_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic              word_o,
  output logic              irq_o
);
  logic [ADDR_W-1:0] src_q, dst_q, src_sh, dst_sh, step;
  logic [CNT_W-1:0]  cnt_q, cnt_sh;
  ctrl_t             ctrl_q;
  logic              pend_q, irq_q, trig, last;

  always_comb begin
    if (ctrl_q.sel == SEL_SW)          trig = sw_trig_i;
    else if (32'(ctrl_q.sel) < NSRC)   trig = req_i[ctrl_q.sel];
    else                               trig = 1'b0;
  end

  assign step = {{(ADDR_W-2){1'b0}}, ctrl_q.word, ~ctrl_q.word};
  assign last = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0; dst_q <= '0; src_sh <= '0; dst_sh <= '0;
      cnt_q <= '0; cnt_sh <= '0; ctrl_q <= '0;
      pend_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      if (wr_src_i) src_q <= wdata_i;
      if (wr_dst_i) dst_q <= wdata_i;
      if (wr_cnt_i) cnt_q <= wdata_i[CNT_W-1:0];
      if (wr_ctrl_i) begin
        ctrl_q <= ctrl_t'(wdata_i[7:0]);
        // capture reload image on enable edge
        if (wdata_i[0] && !ctrl_q.en) begin
          src_sh <= src_q; dst_sh <= dst_q; cnt_sh <= cnt_q;
        end
      end
      if (!ctrl_q.en)           pend_q <= 1'b0;
      else if (trig)            pend_q <= 1'b1;
      else if (start_i)         pend_q <= 1'b0;
      if (irq_clr_i) irq_q <= 1'b0;
      if (done_i) begin
        if (last) begin
          irq_q <= 1'b1;
          if (ctrl_q.rpt) begin
            src_q <= src_sh; dst_q <= dst_sh; cnt_q <= cnt_sh;
          end else begin
            ctrl_q.en <= 1'b0;
            cnt_q     <= '0;
          end
        end else begin
          if (ctrl_q.src_inc) src_q <= src_q + step;
          if (ctrl_q.dst_inc) dst_q <= dst_q + step;
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  assign pend_o = pend_q && ctrl_q.en && (cnt_q != '0);
  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign word_o = ctrl_q.word;
  assign irq_o  = irq_q;
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma2ch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    pend_i,
  input  logic              gnt_i,
  input  logic [ADDR_W-1:0] src_i [NCH],
  input  logic [ADDR_W-1:0] dst_i [NCH],
  input  logic [NCH-1:0]    word_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [NCH-1:0]    start_o,
  output logic [NCH-1:0]    done_o,
  output logic              bus_req_o,
  output logic              bus_en_o,
  output logic              bus_we_o,
  output logic              bus_word_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  eng_st_e           state;
  logic [CH_W-1:0]   act_q, pick;
  logic [DATA_W-1:0] data_q;
  logic              any, take;

  // lowest channel index wins
  always_comb begin
    pick = '0;
    for (int i = NCH-1; i >= 0; i--) if (pend_i[i]) pick = CH_W'(i);
  end

  assign any     = |pend_i;
  assign take    = (state == ST_IDLE) && any && gnt_i;
  assign start_o = take ? (NCH'(1) << pick) : '0;
  assign done_o  = (state == ST_WR) ? (NCH'(1) << act_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state  <= ST_IDLE;
      act_q  <= '0;
      data_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (take) begin
          act_q <= pick;
          state <= ST_RD;
        end
        ST_RD: begin
          data_q <= word_i[act_q] ? rdata_i : {{(DATA_W-8){1'b0}}, rdata_i[7:0]};
          state  <= ST_WR;
        end
        ST_WR:  state <= ST_GAP;
        ST_GAP: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign bus_req_o   = ((state == ST_IDLE) && any) || (state == ST_RD) || (state == ST_WR);
  assign bus_en_o    = (state == ST_RD) || (state == ST_WR);
  assign bus_we_o    = (state == ST_WR);
  assign bus_word_o  = word_i[act_q];
  assign bus_addr_o  = (state == ST_WR) ? dst_i[act_q] : src_i[act_q];
  assign bus_wdata_o = data_q;
endmodule

// File: rtl/dma2ch.sv
module dma2ch
  import dma2ch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  input  logic [5:0]        req_i,
  input  logic              bus_gnt_i,
  input  logic [15:0]       bus_rdata_i,
  output logic              bus_req_o,
  output logic              bus_en_o,
  output logic              bus_we_o,
  output logic              bus_word_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [15:0]       bus_wdata_o,
  output logic [1:0]        irq_o
);
  localparam int DATA_W = 16;

  logic [NCH-1:0]    pend, start, done, word;
  logic [ADDR_W-1:0] src_w [NCH];
  logic [ADDR_W-1:0] dst_w [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = reg_we_i && !reg_addr_i[3] && (reg_addr_i[2] == 1'(c));

    dma_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_src_i  (hit && reg_addr_i[1:0] == 2'd0),
      .wr_dst_i  (hit && reg_addr_i[1:0] == 2'd1),
      .wr_cnt_i  (hit && reg_addr_i[1:0] == 2'd2),
      .wr_ctrl_i (hit && reg_addr_i[1:0] == 2'd3),
      .wdata_i   (reg_wdata_i),
      .sw_trig_i (reg_we_i && reg_addr_i == REG_SWT && reg_wdata_i[c]),
      .req_i     (req_i),
      .irq_clr_i (reg_we_i && reg_addr_i == REG_STAT && reg_wdata_i[c]),
      .start_i   (start[c]),
      .done_i    (done[c]),
      .pend_o    (pend[c]),
      .src_o     (src_w[c]),
      .dst_o     (dst_w[c]),
      .word_o    (word[c]),
      .irq_o     (irq_o[c])
    );
  end

  dma_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pend_i      (pend),
    .gnt_i       (bus_gnt_i),
    .src_i       (src_w),
    .dst_i       (dst_w),
    .word_i      (word),
    .rdata_i     (bus_rdata_i),
    .start_o     (start),
    .done_o      (done),
    .bus_req_o   (bus_req_o),
    .bus_en_o    (bus_en_o),
    .bus_we_o    (bus_we_o),
    .bus_word_o  (bus_word_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o)
  );
endmodule

// File: rtl/dma2ch_chk.sv
module dma2ch_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [3:0]        reg_addr_i,
  input logic [ADDR_W-1:0] reg_wdata_i,
  input logic              bus_gnt_i,
  input logic              bus_req_o,
  input logic              bus_en_o,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [1:0]        irq_o,
  input logic [1:0]        pend_i,
  input logic [ADDR_W-1:0] src0_i
);
  logic clr0, clr1;
  assign clr0 = reg_we_i && reg_addr_i == 4'h8 && reg_wdata_i[0];
  assign clr1 = reg_we_i && reg_addr_i == 4'h8 && reg_wdata_i[1];

  AST_RD_THEN_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_en_o && !bus_we_o |=> bus_en_o && bus_we_o); // R9
  AST_GAP_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_en_o && bus_we_o |=> !bus_req_o && !bus_en_o); // R9
  AST_CYCLE_NEEDS_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_en_o && !bus_we_o |-> $past(bus_gnt_i && bus_req_o && !bus_en_o)); // R12
  AST_CH0_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_en_o && bus_gnt_i && pend_i == 2'b11 |=> bus_addr_o == $past(src0_i)); // R10
  AST_IRQ0_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[0] && !clr0 |=> irq_o[0]); // R11
  AST_IRQ1_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[1] && !clr1 |=> irq_o[1]); // R11
  AST_IRQ0_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr0 && !bus_we_o |=> !irq_o[0]); // R11
endmodule

bind dma2ch dma2ch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .bus_gnt_i   (bus_gnt_i),
  .bus_req_o   (bus_req_o),
  .bus_en_o    (bus_en_o),
  .bus_we_o    (bus_we_o),
  .bus_addr_o  (bus_addr_o),
  .irq_o       (irq_o),
  .pend_i      (pend),
  .src0_i      (src_w[0])
);

// File: tb/sim_dma2ch.sv
`timescale 1ns/1ps
module sim_dma2ch;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [5:0]  req_i = '0;
  logic        bus_gnt_i = 1'b1;
  logic [15:0] bus_rdata_i;
  logic        bus_req_o, bus_en_o, bus_we_o, bus_word_o;
  logic [15:0] bus_addr_o, bus_wdata_o;
  logic [1:0]  irq_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0]  mem [0:1023];
  logic [31:0] exp_q [$];
  string       tag_q [$];
  bit prev_rd = 0, prev_wr = 0;

  always #2.5 clk_i = ~clk_i;

  dma2ch u0 (.*);

  assign bus_rdata_i = bus_word_o ? {mem[bus_addr_o[9:0] + 10'd1], mem[bus_addr_o[9:0]]}
                                  : {8'h00, mem[bus_addr_o[9:0]]};

  always @(posedge clk_i) if (bus_en_o && bus_we_o) begin
    mem[bus_addr_o[9:0]] <= bus_wdata_o[7:0];
    if (bus_word_o) mem[bus_addr_o[9:0] + 10'd1] <= bus_wdata_o[15:8];
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected writes in order
  always @(negedge clk_i) if (rst_ni) begin
    if (prev_wr) chk(!bus_req_o && !bus_en_o, "R9 gap", {bus_req_o, bus_en_o}, 0);
    if (bus_en_o && bus_we_o) begin
      chk(prev_rd, "R9 read precedes write", prev_rd, 1);
      if (exp_q.size() == 0) chk(0, "R5 unexpected write", {bus_addr_o, bus_wdata_o}, 0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({bus_addr_o, bus_wdata_o} == e, t, {bus_addr_o, bus_wdata_o}, e);
      end
    end
    prev_rd = bus_en_o && !bus_we_o;
    prev_wr = bus_en_o && bus_we_o;
  end

  task automatic push(logic [15:0] a, logic [15:0] d, string t);
    exp_q.push_back({a, d});
    tag_q.push_back(t);
  endtask

  function automatic logic [15:0] mb(logic [15:0] a);
    return {8'h00, mem[a[9:0]]};
  endfunction
  function automatic logic [15:0] mw(logic [15:0] a);
    return {mem[a[9:0] + 10'd1], mem[a[9:0]]};
  endfunction
  function automatic logic [15:0] ctl(logic [2:0] sel, bit dinc, bit sinc, bit rpt, bit word, bit en);
    return {8'h00, sel, dinc, sinc, rpt, word, en};
  endfunction

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic cfg(int ch, logic [15:0] s, logic [15:0] d, logic [15:0] n, logic [15:0] c);
    logic [3:0] b;
    b = ch[0] ? 4'h4 : 4'h0;
    wr(b + 4'd3, 16'h0);
    wr(b, s); wr(b + 4'd1, d); wr(b + 4'd2, n); wr(b + 4'd3, c);
  endtask

  task automatic pulse(int k);
    @(negedge clk_i);
    req_i[k] = 1'b1;
    @(negedge clk_i);
    req_i[k] = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hang expected=done");
    report();
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk({bus_req_o, bus_en_o, bus_we_o, irq_o} == 0, "R1 reset", {bus_req_o, bus_en_o, bus_we_o, irq_o}, 0);
    rst_ni = 1'b1;
    idle(2);

    // R2 byte, both increment, ext line
    cfg(0, 16'h010, 16'h200, 3, ctl(3'd0, 1, 1, 0, 0, 1));
    for (int i = 0; i < 3; i++) begin
      push(16'h200 + 16'(i), mb(16'h010 + 16'(i)), "R2 byte increment");
      pulse(0); idle(6);
    end
    chk(irq_o == 2'b01, "R11 irq set on count zero", irq_o, 2'b01);
    // R7 single mode finished: no more transfers
    pulse(0);
    chk(!bus_req_o, "R7 exhausted single channel ignores request", bus_req_o, 0);
    idle(4);
    wr(4'h8, 16'h1);
    chk(irq_o == 2'b00, "R11 write one clears", irq_o, 0);

    // R3 word mode, timer line
    cfg(1, 16'h040, 16'h300, 2, ctl(3'd1, 1, 1, 0, 1, 1));
    for (int i = 0; i < 2; i++) begin
      push(16'h300 + 16'(2 * i), mw(16'h040 + 16'(2 * i)), "R3 word step 2");
      pulse(1); idle(6);
    end
    chk(irq_o == 2'b10, "R11 channel 1 irq", irq_o, 2'b10);
    wr(4'h8, 16'h2);

    // R4 fixed source, A/D line
    cfg(0, 16'h020, 16'h240, 2, ctl(3'd5, 1, 0, 0, 0, 1));
    for (int i = 0; i < 2; i++) begin
      push(16'h240 + 16'(i), mb(16'h020), "R4 fixed source");
      pulse(5); idle(6);
    end
    // R4 fixed destination, UART receive line
    cfg(0, 16'h030, 16'h280, 2, ctl(3'd4, 0, 1, 0, 0, 1));
    for (int i = 0; i < 2; i++) begin
      push(16'h280, mb(16'h030 + 16'(i)), "R4 fixed destination");
      pulse(4); idle(6);
    end

    // R5 only the selected line (UART transmit) starts a transfer
    cfg(0, 16'h0A0, 16'h2C0, 1, ctl(3'd3, 1, 1, 0, 0, 1));
    for (int k = 0; k < 6; k++) if (k != 3) begin
      pulse(k);
      chk(!bus_req_o, "R5 other line ignored", bus_req_o, 0);
    end
    push(16'h2C0, mb(16'h0A0), "R5 selected line");
    pulse(3); idle(6);

    // R6 disabled channel
    cfg(1, 16'h0B0, 16'h2E0, 1, ctl(3'd0, 1, 1, 0, 0, 0));
    pulse(0);
    chk(!bus_req_o, "R6 disabled channel ignores request", bus_req_o, 0);
    idle(4);

    // R13 software trigger
    cfg(1, 16'h0C0, 16'h2F0, 1, ctl(3'd2, 1, 1, 0, 0, 1));
    push(16'h2F0, mb(16'h0C0), "R13 software trigger");
    wr(4'h9, 16'h2); idle(6);
    wr(4'h8, 16'h3);

    // R8 repeat mode reload
    cfg(1, 16'h050, 16'h380, 2, ctl(3'd0, 1, 1, 1, 0, 1));
    push(16'h380, mb(16'h050), "R8 repeat first");
    push(16'h381, mb(16'h051), "R8 repeat second");
    push(16'h380, mb(16'h050), "R8 repeat reloaded");
    for (int i = 0; i < 3; i++) begin pulse(0); idle(6); end
    chk(irq_o[1] == 1'b1, "R8 irq on reload", irq_o[1], 1);
    wr(4'h7, 16'h0);
    wr(4'h8, 16'h3);

    // R12 grant withheld
    bus_gnt_i = 1'b0;
    cfg(0, 16'h060, 16'h3A0, 1, ctl(3'd1, 1, 1, 0, 0, 1));
    pulse(1); idle(5);
    chk(bus_req_o && !bus_en_o, "R12 waits for grant", {bus_req_o, bus_en_o}, 2'b10);
    push(16'h3A0, mb(16'h060), "R12 after grant");
    bus_gnt_i = 1'b1;
    idle(8);

    // R10 both pending, channel 0 first
    bus_gnt_i = 1'b0;
    cfg(0, 16'h070, 16'h3C0, 1, ctl(3'd0, 1, 1, 0, 0, 1));
    cfg(1, 16'h078, 16'h3E0, 1, ctl(3'd0, 1, 1, 0, 0, 1));
    push(16'h3C0, mb(16'h070), "R10 channel 0 first");
    push(16'h3E0, mb(16'h078), "R10 channel 1 second");
    pulse(0); idle(2);
    bus_gnt_i = 1'b1;
    idle(14);
    chk(irq_o == 2'b11, "R11 both flags", irq_o, 2'b11);

    chk(exp_q.size() == 0, "R2 all expected writes seen", exp_q.size(), 0);
    report();
  end
endmodule